// File: doc/BRIEF.md
# Synchronous Burst Flash Read Sequencer

This block runs one synchronous burst read from a NOR-type memory on a parallel bus. When idle, it accepts a request made of a start pulse, an address and a burst length. It then produces the memory clock enable and three active-low strobes: chip select, address valid and output enable. It also samples the memory data bus once for each burst beat.

Each event is placed by its own cycle count, measured from the accepting edge. These events are the on and off edge of every strobe, the memory clock start, the first data capture, the spacing between later beats, and the end of the cycle. Software turns nanosecond memory parameters into these counts by rounding up and holds them on the configuration inputs. The block copies them when it accepts a request.

Longer bursts push the end of the cycle out by one beat spacing for each extra beat. The chip-select and output-enable release points move out with it. If a configuration is inconsistent, the block refuses the request and gives an error pulse instead of starting.

Top module: `burstRdSeq`

## Requirements
- R1: After reset, memCsN, memAdvN and memOeN are 1 and memClkEn, beatValid, busy, done and cfgErr are 0.
- R2: An event at offset t appears on the outputs at the (t+1)-th rising edge after the edge that accepts start. For every offset t that is below the end, memCsN is 0 when csOnCyc <= t < csOffCyc + ext, and 1 otherwise. Here ext = burstLen * burstAccCyc.
- R3: For every offset t below the end, memAdvN is 0 exactly when advOnCyc <= t < advOffCyc. Otherwise it is 1.
- R4: For every offset t below the end, memOeN is 0 exactly when oeOnCyc <= t < oeOffCyc + ext. Otherwise it is 1.
- R5: memClkEn is 1 exactly for the offsets t with clkActCyc <= t < end.
- R6: dataIn is sampled at offset rdAccCyc. The sampled value shows on dataOut with beatValid high for one cycle.
- R7: A burst has burstLen+1 beats (a field value of 0 means one beat). Each further beat is sampled burstAccCyc offsets after the one before it.
- R8: The end of the cycle is end = rdCycCyc + ext.
- R9: done is high for exactly one cycle, at the (end+1)-th edge after acceptance. busy is high from the accepting edge until that edge. All strobes are inactive whenever busy is low.
- R10: The configuration is invalid in any of these cases: csOffCyc <= csOnCyc, advOffCyc <= advOnCyc, oeOffCyc <= oeOnCyc, rdAccCyc <= clkActCyc, or rdCycCyc <= rdAccCyc. A start while idle with an invalid configuration gives a one-cycle cfgErr pulse and starts no access.
- R11: A start while busy is ignored. memAddr holds the address captured at the accepting edge until the access finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| addrIn | input | AW | Read address |
| burstLen | input | LW | Beats minus one |
| clkActCyc | input | CW | Memory clock start offset |
| rdAccCyc | input | CW | First data capture offset |
| burstAccCyc | input | CW | Spacing between beats |
| rdCycCyc | input | CW | Single-beat cycle length |
| csOnCyc | input | CW | Chip-select assert offset |
| csOffCyc | input | CW | Chip-select release offset |
| advOnCyc | input | CW | Address-valid assert offset |
| advOffCyc | input | CW | Address-valid release offset |
| oeOnCyc | input | CW | Output-enable assert offset |
| oeOffCyc | input | CW | Output-enable release offset |
| dataIn | input | DW | Memory data bus |
| memClkEn | output | 1 | Memory clock enable |
| memCsN | output | 1 | Chip select, active low |
| memAdvN | output | 1 | Address valid, active low |
| memOeN | output | 1 | Output enable, active low |
| memAddr | output | AW | Address held for the access |
| dataOut | output | DW | Captured beat |
| beatValid | output | 1 | dataOut holds a new beat |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| cfgErr | output | 1 | One-cycle rejected-request pulse |

## Verification
The hardest case to reach is a second start that arrives in the middle of a running burst with a different address. The accepted access's address and its strobe timeline must not change. The burst task pulses start and changes addrIn part-way through the access. It then compares every strobe, beat and memAddr against the timeline it computed for the first request, cycle by cycle. The task also drives a distinct data value on every cycle, so a beat sampled one offset early or late shows up as a wrong dataOut value.

// File: rtl/brs_pkg.sv
package brsPkg;
  // strobes from the sequencing control to the output datapath
  typedef struct packed {
    logic cs;
    logic adv;
    logic oe;
    logic clkEn;
    logic capture;
    logic load;
  } strobe_t;
endpackage

// File: rtl/brs_ctrl.sv
module brsCtrl
  import brsPkg::*;
#(
  parameter int CW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] burstLen,
  input  logic [CW-1:0] clkActCyc,
  input  logic [CW-1:0] rdAccCyc,
  input  logic [CW-1:0] burstAccCyc,
  input  logic [CW-1:0] rdCycCyc,
  input  logic [CW-1:0] csOnCyc,
  input  logic [CW-1:0] csOffCyc,
  input  logic [CW-1:0] advOnCyc,
  input  logic [CW-1:0] advOffCyc,
  input  logic [CW-1:0] oeOnCyc,
  input  logic [CW-1:0] oeOffCyc,
  output strobe_t       stb,
  output logic          busy,
  output logic          done,
  output logic          cfgErr
);
  localparam int EW = CW + LW + 1;

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  logic [EW-1:0] cnt, endQ, nextBeat;
  logic [EW-1:0] csOnQ, csOffQ, advOnQ, advOffQ, oeOnQ, oeOffQ, clkActQ, burstAccQ;
  logic [LW:0]   beatsLeft;
  logic [EW-1:0] ext;
  logic          cfgOk, accept, running, inWin;

  assign cfgOk = (csOffCyc > csOnCyc) && (advOffCyc > advOnCyc) &&
                 (oeOffCyc > oeOnCyc) && (rdAccCyc > clkActCyc) &&
                 (rdCycCyc > rdAccCyc);
  assign accept = start && (state == S_IDLE) && cfgOk;
  assign ext = EW'(burstLen) * EW'(burstAccCyc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      endQ      <= '0;
      nextBeat  <= '0;
      beatsLeft <= '0;
      csOnQ     <= '0;
      csOffQ    <= '0;
      advOnQ    <= '0;
      advOffQ   <= '0;
      oeOnQ     <= '0;
      oeOffQ    <= '0;
      clkActQ   <= '0;
      burstAccQ <= '0;
      done      <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      done   <= (state == S_RUN) && (cnt == endQ);
      cfgErr <= start && (state == S_IDLE) && !cfgOk;
      if (accept) begin
        state     <= S_RUN;
        cnt       <= '0;
        endQ      <= EW'(rdCycCyc) + ext;
        nextBeat  <= EW'(rdAccCyc);
        beatsLeft <= (LW+1)'(burstLen) + 1'b1;
        csOnQ     <= EW'(csOnCyc);
        csOffQ    <= EW'(csOffCyc) + ext;
        advOnQ    <= EW'(advOnCyc);
        advOffQ   <= EW'(advOffCyc);
        oeOnQ     <= EW'(oeOnCyc);
        oeOffQ    <= EW'(oeOffCyc) + ext;
        clkActQ   <= EW'(clkActCyc);
        burstAccQ <= EW'(burstAccCyc);
      end else if (state == S_RUN) begin
        cnt <= cnt + 1'b1;
        if (stb.capture) begin
          beatsLeft <= beatsLeft - 1'b1;
          nextBeat  <= nextBeat + burstAccQ;
        end
        if (cnt == endQ) state <= S_IDLE;
      end
    end
  end

  assign running = (state == S_RUN);
  assign inWin   = running && (cnt < endQ);
  assign busy    = running;

  always_comb begin
    stb         = '0;
    stb.cs      = inWin && (cnt >= csOnQ) && (cnt < csOffQ);
    stb.adv     = inWin && (cnt >= advOnQ) && (cnt < advOffQ);
    stb.oe      = inWin && (cnt >= oeOnQ) && (cnt < oeOffQ);
    stb.clkEn   = inWin && (cnt >= clkActQ);
    stb.capture = running && (beatsLeft != '0) && (cnt == nextBeat);
    stb.load    = accept;
  end
endmodule

// File: rtl/brs_datapath.sv
module brsDatapath
  import brsPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  output logic          memClkEn,
  output logic          memCsN,
  output logic          memAdvN,
  output logic          memOeN,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] dataOut,
  output logic          beatValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memClkEn  <= 1'b0;
      memCsN    <= 1'b1;
      memAdvN   <= 1'b1;
      memOeN    <= 1'b1;
      memAddr   <= '0;
      dataOut   <= '0;
      beatValid <= 1'b0;
    end else begin
      memClkEn  <= stb.clkEn;
      memCsN    <= ~stb.cs;
      memAdvN   <= ~stb.adv;
      memOeN    <= ~stb.oe;
      beatValid <= stb.capture;
      if (stb.load)    memAddr <= addrIn;
      if (stb.capture) dataOut <= dataIn;
    end
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burstRdSeq
  import brsPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] addrIn,
  input  logic [LW-1:0] burstLen,
  input  logic [CW-1:0] clkActCyc,
  input  logic [CW-1:0] rdAccCyc,
  input  logic [CW-1:0] burstAccCyc,
  input  logic [CW-1:0] rdCycCyc,
  input  logic [CW-1:0] csOnCyc,
  input  logic [CW-1:0] csOffCyc,
  input  logic [CW-1:0] advOnCyc,
  input  logic [CW-1:0] advOffCyc,
  input  logic [CW-1:0] oeOnCyc,
  input  logic [CW-1:0] oeOffCyc,
  input  logic [DW-1:0] dataIn,
  output logic          memClkEn,
  output logic          memCsN,
  output logic          memAdvN,
  output logic          memOeN,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] dataOut,
  output logic          beatValid,
  output logic          busy,
  output logic          done,
  output logic          cfgErr
);
  strobe_t stb;

  brsCtrl #(.CW(CW), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .burstLen(burstLen),
    .clkActCyc(clkActCyc), .rdAccCyc(rdAccCyc), .burstAccCyc(burstAccCyc),
    .rdCycCyc(rdCycCyc), .csOnCyc(csOnCyc), .csOffCyc(csOffCyc),
    .advOnCyc(advOnCyc), .advOffCyc(advOffCyc), .oeOnCyc(oeOnCyc),
    .oeOffCyc(oeOffCyc), .stb(stb), .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  brsDatapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addrIn(addrIn), .dataIn(dataIn),
    .memClkEn(memClkEn), .memCsN(memCsN), .memAdvN(memAdvN), .memOeN(memOeN),
    .memAddr(memAddr), .dataOut(dataOut), .beatValid(beatValid)
  );
endmodule

// File: rtl/burst_rd_seq_chk.sv
module burstRdSeqChk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          memClkEn,
  input logic          memCsN,
  input logic          memAdvN,
  input logic          memOeN,
  input logic [AW-1:0] memAddr,
  input logic          beatValid,
  input logic          busy,
  input logic          done,
  input logic          cfgErr
);
  p_idle_strobes_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCsN && memAdvN && memOeN && !memClkEn));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_at_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_err_no_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busy);

  p_beat_inside_r6: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> busy);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));
endmodule

bind burstRdSeq burstRdSeqChk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memClkEn(memClkEn), .memCsN(memCsN),
  .memAdvN(memAdvN), .memOeN(memOeN), .memAddr(memAddr),
  .beatValid(beatValid), .busy(busy), .done(done), .cfgErr(cfgErr)
);

// File: tb/sim_burstRdSeq.sv
module sim_burstRdSeq;
  localparam int AW = 24, DW = 16, CW = 8, LW = 4;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [LW-1:0] burstLen = '0;
  logic [CW-1:0] clkActCyc = '0, rdAccCyc = '0, burstAccCyc = '0, rdCycCyc = '0;
  logic [CW-1:0] csOnCyc = '0, csOffCyc = '0, advOnCyc = '0, advOffCyc = '0;
  logic [CW-1:0] oeOnCyc = '0, oeOffCyc = '0;
  logic [DW-1:0] dataIn = '0;
  logic memClkEn, memCsN, memAdvN, memOeN, beatValid, busy, done, cfgErr;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] dataOut;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  burstRdSeq #(.AW(AW), .DW(DW), .CW(CW), .LW(LW)) u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int ca, ra, ba, rc, con, coff, aon, aoff, oon, ooff);
    clkActCyc = CW'(ca); rdAccCyc = CW'(ra); burstAccCyc = CW'(ba); rdCycCyc = CW'(rc);
    csOnCyc = CW'(con); csOffCyc = CW'(coff); advOnCyc = CW'(aon); advOffCyc = CW'(aoff);
    oeOnCyc = CW'(oon); oeOffCyc = CW'(ooff);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "memCsN", memCsN, 1);
    chk("R1", "memAdvN", memAdvN, 1);
    chk("R1", "memOeN", memOeN, 1);
    chk("R1", "memClkEn", memClkEn, 0);
    chk("R1", "flags", {beatValid, busy, done, cfgErr}, 0);
  endtask

  // full access, compared cycle by cycle against the computed timeline
  task automatic runAccess(input int ca, ra, ba, rc, con, coff, aon, aoff, oon, ooff,
                           input int n, input int addr, input bit poke);
    int ext, endc, t;
    bit beat;
    ext  = (n - 1) * ba;
    endc = rc + ext;
    setCfg(ca, ra, ba, rc, con, coff, aon, aoff, oon, ooff);
    burstLen = LW'(n - 1);
    addrIn = AW'(addr);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    dataIn = DW'(16'h5000);
    for (int k = 1; k <= endc + 3; k++) begin
      @(negedge clk);
      t = k - 1;
      chk("R2", "memCsN", memCsN, (t < endc && t >= con && t < coff + ext) ? 0 : 1);
      chk("R3", "memAdvN", memAdvN, (t < endc && t >= aon && t < aoff) ? 0 : 1);
      chk("R4", "memOeN", memOeN, (t < endc && t >= oon && t < ooff + ext) ? 0 : 1);
      chk("R5", "memClkEn", memClkEn, (t < endc && t >= ca) ? 1 : 0);
      beat = (t >= ra) && ((t - ra) % ba == 0) && ((t - ra) / ba < n);
      chk("R7", "beatValid", beatValid, beat ? 1 : 0);
      if (beat) chk("R6", "dataOut", dataOut, 16'h5000 + t);
      chk("R8", "busy", busy, (k <= endc) ? 1 : 0);
      chk("R9", "done", done, (k == endc + 1) ? 1 : 0);
      if (k <= endc) chk("R11", "memAddr", memAddr, addr);
      if (poke && k == 5) begin start = 1'b1; addrIn = AW'(addr ^ 24'hFFFFFF); end
      else start = 1'b0;
      dataIn = DW'(16'h5000 + k);
    end
    start = 1'b0;
  endtask

  task automatic badCfg(input int ca, ra, ba, rc, con, coff, aon, aoff, oon, ooff);
    setCfg(ca, ra, ba, rc, con, coff, aon, aoff, oon, ooff);
    burstLen = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "cfgErr", cfgErr, 1);
    chk("R10", "busy", busy, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10", "cfgErr after", cfgErr, 0);
      chk("R10", "strobes", {memCsN, memAdvN, memOeN, memClkEn, busy}, 5'b11100);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    // single beat with the worked example timing
    runAccess(1, 10, 1, 11, 0, 11, 0, 2, 3, 11, 1, 24'h012345, 1'b0);
    // four-beat burst, end and releases pushed out
    runAccess(1, 10, 1, 11, 0, 11, 0, 2, 3, 11, 4, 24'h00ABCD, 1'b0);
    // different spacing, late strobes, a start arriving while busy
    runAccess(2, 5, 2, 8, 1, 8, 1, 3, 4, 8, 3, 24'h3C0F0F, 1'b1);
    // maximum burst with wider beat spacing
    runAccess(1, 4, 3, 6, 0, 6, 0, 2, 2, 5, 16, 24'h7E0001, 1'b0);
    // rejected configurations
    badCfg(1, 10, 1, 11, 4, 4, 0, 2, 3, 11);
    badCfg(5, 5, 1, 11, 0, 11, 0, 2, 3, 11);
    badCfg(1, 10, 1, 10, 0, 11, 0, 2, 3, 11);
    // block still works after a rejection
    runAccess(1, 3, 1, 5, 0, 5, 0, 1, 2, 5, 2, 24'h000042, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule